// File: doc/BRIEF.md
# Leveled Interrupt Controller with Fast Path

This block gathers interrupt requests from eight active-low external pins and thirteen active-high on-chip peripheral lines. It also takes one active-low fast-request pin, which bypasses all arbitration and drives the CPU's fast exception output. Software gives every ordinary source a 3-bit priority level, and level 0 switches a source off. Among the pending sources whose level beats the level currently in service, the highest level wins. When two sources share a level, the lower source number wins. The normal exception output is raised while such a winner exists.

Software serves an interrupt by reading the number register. The read returns the winner's number and acknowledges it, and the winner's level is pushed onto an in-service stack. From then on, only strictly higher levels can raise the normal exception, until an end-of-interrupt write pops the stack. Each external pin can be set to level or edge sensitivity. A request on a pin in edge mode stays latched until software clears it.

The register map is word-addressed:

| Address | Access | Function |
|---|---|---|
| 0 | read | number register; reading it acknowledges the winner |
| 1 | write | end of interrupt (any data) |
| 2 | write | edge-mode mask, bit k for external pin k |
| 3 | write | edge-latch clear, a 1 in bit k clears pin k |
| 4 | read | level currently in service, in bits [2:0] |
| 8 + n | write | level of source n, in bits [2:0] |

Read data is registered and appears one clock after the read strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are 0, rdata_o is 0, every source level is 0, the in-service level read at address 4 is 0, and every external pin is in level mode.
- R2: fiq_o equals the inverse of fiq_n_i as sampled at the previous clock edge. The fast pin never affects irq_o or the number register.
- R3: A source whose level is 0 never raises irq_o and is never reported by the number register, even while it is asserted.
- R4: The number register reports, in bits [4:0], the pending enabled source with the highest level. Source numbers are 0 to 7 for ext_irq_n_i[0..7] and 8 to 20 for per_irq_i[0..12]. Bit 7 is set when a source is reported.
- R5: When pending sources share the highest level, the source with the lowest number is reported.
- R6: A request on an enabled source, with a level above the in-service level, raises irq_o two clock edges after the request input changes.
- R7: An external pin in edge mode latches a high-to-low transition. The request stays pending after the pin returns high, and it is cleared only by writing a 1 to its bit at address 3.
- R8: An external pin in level mode stops requesting two clock edges after it returns high.
- R9: A number read that reports a source pushes that source's level, which becomes the in-service level. A pending source at or below the in-service level does not raise irq_o.
- R10: A write to address 1 pops the in-service stack and restores the previous in-service level, or 0 when the stack empties. Pending sources at the restored level then raise irq_o again.
- R11: A number read when no source qualifies returns bit 7 = 0 and number 31, and leaves the in-service level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| fiq_n_i | input | 1 | Active-low fast request pin |
| ext_irq_n_i | input | 8 | Active-low external request pins |
| per_irq_i | input | 13 | Active-high peripheral request lines |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Normal interrupt request to the CPU |
| fiq_o | output | 1 | Fast interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: eight external pins, thirteen peripheral lines and 3-bit levels. At this size every source can be swept once while disabled and once while enabled. The same configuration makes a full 7-by-7 sweep of level pairs between an external source and a peripheral source cheap. That sweep covers every win, loss and tie outcome. The seven possible levels also make stack nesting and its preemption limits reachable in a few dozen cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_NUM      = 0;
  localparam int unsigned REG_EOI      = 1;
  localparam int unsigned REG_EDGE     = 2;
  localparam int unsigned REG_CLR      = 3;
  localparam int unsigned REG_CUR      = 4;
  localparam int unsigned REG_LVL_BASE = 8;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] pin_n_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] samp_q, samp_d;
  logic [N-1:0] latch_q, latch_d;

  always_comb begin
    samp_d  = ~pin_n_i;
    latch_d = (latch_q & ~clr_i) | (edge_mode_i & ~pin_n_i & ~samp_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      samp_q  <= '0;
      latch_q <= '0;
    end else begin
      samp_q  <= samp_d;
      latch_q <= latch_d;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_sel
    assign pend_o[k] = edge_mode_i[k] ? latch_q[k] : samp_q[k];
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int unsigned NSRC   = 21,
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [NSRC*LVL_W-1:0]   lvl_flat_o,
  output logic [N_EXT-1:0]        edge_mode_o,
  output logic [N_EXT-1:0]        clr_o,
  output logic                    eoi_o
);
  logic             edge_we;
  logic [N_EXT-1:0] edge_q, edge_d;

  assign edge_we = wr_en_i && (addr_i == ADDR_W'(REG_EDGE));
  assign clr_o   = (wr_en_i && (addr_i == ADDR_W'(REG_CLR))) ? wdata_i[N_EXT-1:0] : '0;
  assign eoi_o   = wr_en_i && (addr_i == ADDR_W'(REG_EOI));

  always_comb begin
    edge_d = edge_q;
    if (edge_we) edge_d = wdata_i[N_EXT-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) edge_q <= '0;
    else          edge_q <= edge_d;
  end

  assign edge_mode_o = edge_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    logic             we;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    assign we = wr_en_i && (addr_i == ADDR_W'(REG_LVL_BASE + s));
    always_comb begin
      lvl_d = lvl_q;
      if (we) lvl_d = wdata_i[LVL_W-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) lvl_q <= '0;
      else          lvl_q <= lvl_d;
    end
    assign lvl_flat_o[s*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N     = 21,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]       pend_i,
  input  logic [N*LVL_W-1:0] lvl_flat_i,
  input  logic [LVL_W-1:0]   floor_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [LVL_W-1:0]   lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '1;
    lvl_o   = floor_i;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lowest index on a tie
      if (pend_i[i] && (lvl_flat_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_flat_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned W     = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         push_i,
  input  logic [W-1:0] push_val_i,
  input  logic         pop_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] sp_q, sp_d;
  logic [W-1:0]     mem_q [DEPTH];
  logic             do_push, do_pop;

  assign do_push = push_i && (sp_q != PTR_W'(DEPTH));
  assign do_pop  = !push_i && pop_i && (sp_q != '0);

  always_comb begin
    sp_d = sp_q;
    if (do_push)     sp_d = sp_q + 1'b1;
    else if (do_pop) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sp_q <= '0;
    else          sp_q <= sp_d;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (do_push && (sp_q == PTR_W'(e))) mem_q[e] <= push_val_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (sp_q == PTR_W'(e + 1)) top_o = mem_q[e];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned N_PER  = 13,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              fiq_n_i,
  input  logic [N_EXT-1:0]  ext_irq_n_i,
  input  logic [N_PER-1:0]  per_irq_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned NSRC  = N_EXT + N_PER;
  localparam int unsigned IDX_W = $clog2(NSRC + 1);
  localparam int unsigned DEPTH = (1 << LVL_W) - 1;

  logic [1:0]            rst_sync_q;
  logic                  rst_n;
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic [N_EXT-1:0]      edge_mode, clr;
  logic                  eoi;
  logic [N_EXT-1:0]      ext_pend;
  logic [N_PER-1:0]      per_q;
  logic [NSRC-1:0]       pend;
  logic [LVL_W-1:0]      cur_lvl;
  logic                  best_vld;
  logic [IDX_W-1:0]      best_idx;
  logic [LVL_W-1:0]      best_lvl;
  logic                  ack;
  logic                  irq_q, fiq_q;
  logic [DATA_W-1:0]     rdata_q, rdata_d;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  irq_cfg_regs #(.NSRC(NSRC), .N_EXT(N_EXT), .LVL_W(LVL_W),
                 .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i(clk_i), .rst_n_i(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .lvl_flat_o(lvl_flat), .edge_mode_o(edge_mode),
    .clr_o(clr), .eoi_o(eoi)
  );

  irq_src_latch #(.N(N_EXT)) u_ext (
    .clk_i(clk_i), .rst_n_i(rst_n), .pin_n_i(ext_irq_n_i),
    .edge_mode_i(edge_mode), .clr_i(clr), .pend_o(ext_pend)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= per_irq_i;
  end

  assign pend = {per_q, ext_pend};

  irq_arbiter #(.N(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .pend_i(pend), .lvl_flat_i(lvl_flat), .floor_i(cur_lvl),
    .valid_o(best_vld), .idx_o(best_idx), .lvl_o(best_lvl)
  );

  assign ack = rd_en_i && (addr_i == ADDR_W'(REG_NUM));

  irq_lvl_stack #(.DEPTH(DEPTH), .W(LVL_W)) u_stk (
    .clk_i(clk_i), .rst_n_i(rst_n), .push_i(ack && best_vld),
    .push_val_i(best_lvl), .pop_i(eoi), .top_o(cur_lvl)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) begin
      rdata_d = '0;
      if (addr_i == ADDR_W'(REG_NUM)) begin
        rdata_d[DATA_W-1]  = best_vld;
        rdata_d[IDX_W-1:0] = best_idx;
      end else if (addr_i == ADDR_W'(REG_CUR)) begin
        rdata_d[LVL_W-1:0] = cur_lvl;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= best_vld;
      fiq_q   <= ~fiq_n_i;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              fiq_n_i,
  input logic              fiq_o,
  input logic              irq_o,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [LVL_W-1:0]  cur_lvl_i
);
  // R2: fast output mirrors the pin one edge later
  a_r2_fiq_follows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(rst_n_i) |-> (fiq_o == !$past(fiq_n_i)));

  // R9: an acknowledged number raises the in-service level
  a_r9_push_raises: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && addr_i == '0) |=> (!rdata_o[DATA_W-1] || (cur_lvl_i > $past(cur_lvl_i))));

  // R9: nothing can preempt the top level
  a_r9_top_blocks: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cur_lvl_i == '1) |=> !irq_o);

  // R10: end of interrupt lowers the in-service level
  a_r10_eoi_lowers: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && !rd_en_i && addr_i == ADDR_W'(1) && cur_lvl_i != '0) |=>
      (cur_lvl_i < $past(cur_lvl_i)));

  // R11: an empty number read carries the no-source code
  a_r11_empty_code: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && addr_i == '0) |=> (rdata_o[DATA_W-1] || (rdata_o[IDX_W-1:0] == '1)));

  // R11: an empty number read leaves the in-service level alone
  a_r11_no_push: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && !wr_en_i && addr_i == '0) |=> (rdata_o[DATA_W-1] || $stable(cur_lvl_i)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_n_i(rst_n), .fiq_n_i(fiq_n_i), .fiq_o(fiq_o),
  .irq_o(irq_o), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .cur_lvl_i(cur_lvl)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fiq_n;
  logic [7:0]  ext_n;
  logic [12:0] per;
  logic        rd_en, wr_en;
  logic [4:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .fiq_n_i(fiq_n), .ext_irq_n_i(ext_n),
    .per_irq_i(per), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = 5'(a);
    @(negedge clk); rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic drive_src(input int s, input bit on);
    if (s < 8) ext_n[s] = ~on;
    else       per[s-8] = on;
  endtask

  initial begin
    int d;
    rst_n = 1'b0; fiq_n = 1'b1; ext_n = '1; per = '0;
    rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    tick(3); rst_n = 1'b1; tick(3);

    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 fiq", fiq, 0); chk("R1 rdata", rdata, 0);
    rd(4, d); chk("R1 cur level", d, 0);
    rd(0, d); chk("R1 number empty", d, 31);

    // R2 fast path
    fiq_n = 1'b0; tick(1); chk("R2 fiq set", fiq, 1); chk("R2 irq untouched", irq, 0);
    rd(0, d); chk("R2 number untouched", d, 31);
    fiq_n = 1'b1; tick(1); chk("R2 fiq clear", fiq, 0);

    // per-source sweep: disabled then enabled
    for (int s = 0; s < 21; s++) begin
      drive_src(s, 1'b1); tick(3);
      chk("R3 disabled irq", irq, 0);
      rd(0, d); chk("R3 R11 disabled number", d, 31);
      wr(8 + s, (s % 7) + 1); tick(2);
      chk("R6 irq raised", irq, 1);
      rd(0, d); chk("R4 number", d, 128 + s);
      wr(1, 0);
      drive_src(s, 1'b0); wr(8 + s, 0); tick(2);
    end

    // level pair sweep: ext source 2 against peripheral source 10
    drive_src(2, 1'b1); drive_src(10, 1'b1);
    for (int la = 1; la < 8; la++) begin
      for (int lb = 1; lb < 8; lb++) begin
        int expn;
        wr(8 + 2, la); wr(8 + 10, lb);
        expn = (lb > la) ? 10 : 2;
        rd(0, d);
        if (la == lb) chk("R5 tie number", d, 128 + expn);
        else          chk("R4 level winner", d, 128 + expn);
        rd(4, d); chk("R9 pushed level", d, (la > lb) ? la : lb);
        wr(1, 0);
      end
    end
    drive_src(2, 1'b0); drive_src(10, 1'b0); wr(10, 0); wr(18, 0); tick(2);

    // preemption and stack
    wr(8, 4); wr(9, 4); wr(11, 5);
    drive_src(0, 1'b1); tick(2);
    rd(0, d); chk("R9 first ack", d, 128);
    rd(4, d); chk("R9 level 4 in service", d, 4);
    drive_src(1, 1'b1); tick(3);
    chk("R9 equal level blocked", irq, 0);
    rd(0, d); chk("R11 blocked read", d, 31);
    rd(4, d); chk("R11 no push", d, 4);
    drive_src(3, 1'b1); tick(3);
    chk("R9 higher preempts", irq, 1);
    rd(0, d); chk("R9 nested ack", d, 128 + 3);
    rd(4, d); chk("R9 level 5 in service", d, 5);
    wr(1, 0); rd(4, d); chk("R10 pop to 4", d, 4);
    wr(1, 0); rd(4, d); chk("R10 pop to 0", d, 0);
    tick(2); chk("R10 irq returns", irq, 1);
    drive_src(0, 1'b0); drive_src(1, 1'b0); drive_src(3, 1'b0);
    wr(8, 0); wr(9, 0); wr(11, 0); tick(2);
    chk("R3 idle after cleanup", irq, 0);

    // R7 edge mode on pin 5
    wr(8 + 5, 6); wr(2, 8'h20);
    @(negedge clk); ext_n[5] = 1'b0;
    @(negedge clk); ext_n[5] = 1'b1;
    tick(1); chk("R7 edge latched", irq, 1);
    tick(3); chk("R7 held after release", irq, 1);
    rd(0, d); chk("R7 number", d, 128 + 5);
    wr(1, 0); tick(2); chk("R7 still pending", irq, 1);
    wr(3, 8'h20); tick(2); chk("R7 cleared", irq, 0);
    wr(2, 0); wr(8 + 5, 0);

    // R8 level mode on pin 6
    wr(8 + 6, 6);
    ext_n[6] = 1'b0; tick(2); chk("R8 level asserted", irq, 1);
    ext_n[6] = 1'b1; tick(2); chk("R8 level released", irq, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule